// File: doc/BRIEF.md
# Wake Event Status Register

This block records which wake-up sources asked for a soft power-on. It has one 8-bit status byte, which is read through an index/strobe configuration bus.

Six of the eight bits are sticky:

- Five external pins set their bit when the pin goes from high to low: the ring indicators of two serial ports, the keyboard clock, the mouse clock and a second infrared receive line.
- An internal alarm level sets the top bit.

A read of the status byte returns the bits and clears all six sticky bits. The two remaining bits follow the group interrupt levels 1 and 2 directly. They are not stored, so they fall only when the source lets go of them.

A combined wake request is high while any status bit is 1. The power sequencer uses it to start power-on. The external pins are asynchronous and pass through a synchronizer before edge detection. The battery-side power-on reset loads the byte with 0x00. A read that lands in the same cycle as a new event never loses that event.

Top module: `wake_status_reg`

## Requirements
- R1: While the battery reset is asserted and after its release, the status byte is 0x00, `cfg_rdata` is 0x00 and `wake_req` is low until an event occurs.
- R2: A read is a cycle with `cfg_strobe`=1, `cfg_write`=0 and `cfg_index`=0xB2. It loads `cfg_rdata` at that clock edge with the status byte. A read strobe to any other index loads 0x00 and leaves the status bits unchanged.
- R3: A high-to-low transition on a pin sets its status bit. The pins and bits are: ring of port 1 on bit 0, ring of port 2 on bit 1, keyboard clock on bit 2, mouse clock on bit 3, infrared receive on bit 6. The bit becomes set at the third rising clock edge after the pin falls.
- R4: A rising edge on a pin, or a pin held low, sets no bit beyond the single set caused by its one falling edge.
- R5: The alarm level, when high in a cycle, sets bit 7 at that cycle's clock edge.
- R6: A read returns the bits as they were before the edge and clears bits 0–3, 6 and 7.
- R7: Bits 4 and 5 show the current levels of group interrupt 1 and 2. They are not stored and are not cleared by a read.
- R8: When a set condition and a clearing read meet at the same edge, the read returns the old value and the bit is 1 after the edge.
- R9: `wake_req` is the OR of all eight status bits, including the live bits 4 and 5.
- R10: A cycle with `cfg_strobe`=1 and `cfg_write`=1 changes neither the status bits nor `cfg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| vbat_rst_n | input | 1 | Battery power-on reset, active low, asynchronous |
| ser1_ring_n | input | 1 | Ring indicator pin of serial port 1 (asynchronous) |
| ser2_ring_n | input | 1 | Ring indicator pin of serial port 2 (asynchronous) |
| kbd_clk | input | 1 | Keyboard clock pin (asynchronous) |
| mouse_clk | input | 1 | Mouse clock pin (asynchronous) |
| ir_rx2 | input | 1 | Second infrared receive pin (asynchronous) |
| alarm_lvl | input | 1 | Internal alarm level (synchronous) |
| grp_int1 | input | 1 | Internal group interrupt 1 level |
| grp_int2 | input | 1 | Internal group interrupt 2 level |
| cfg_strobe | input | 1 | Configuration access strobe, one cycle |
| cfg_write | input | 1 | 1 marks the access as a write, 0 as a read |
| cfg_index | input | IDX_W | Register index of the access |
| cfg_rdata | output | 8 | Read data, loaded at the edge of a read strobe |
| wake_req | output | 1 | OR of all status bits |

## Verification
Each result is due a fixed number of clock edges after its stimulus:

- A pin falling edge shows up in the status byte at the third rising edge after the pin is driven.
- The alarm level is taken at the next edge.
- `cfg_rdata` changes at the edge of the read strobe itself.
- `wake_req` follows the group interrupt levels in the same cycle.

The bench drives all inputs on the falling clock edge. It keeps a history of the last three pin values, so its model sets each bit at the edge where it is due. Every output is compared one nanosecond after each rising edge. The collision case is placed exactly: a read is issued two cycles after a pin falls, so that the set and the clear meet at the same edge.

// File: rtl/wake_pkg.sv
package wake_pkg;
   localparam int unsigned STAT_W    = 8;
   localparam int unsigned NUM_PINS  = 5;
   localparam int unsigned BIT_GI1   = 4;
   localparam int unsigned BIT_GI2   = 5;
   localparam int unsigned BIT_ALARM = 7;
   localparam logic [STAT_W-1:0] LIVE_MASK =
      (STAT_W'(1) << BIT_GI1) | (STAT_W'(1) << BIT_GI2);

   // status bit position for each external pin, pin order as wired in the top
   function automatic int unsigned pin_pos(input int unsigned idx);
      case (idx)
         0:       return 0;
         1:       return 1;
         2:       return 2;
         3:       return 3;
         default: return 6;
      endcase
   endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
   parameter int unsigned WIDTH     = 1,
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wake_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("wake_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= {WIDTH{RESET_VAL}};
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wake_fall_det.sv
module wake_fall_det #(
   parameter int unsigned WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] fall_o
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= lvl_i;
   end

   assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/wake_sticky_bank.sv
module wake_sticky_bank #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic             clr_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] q_q;

   // a set on the clearing edge wins, so no event is dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_q <= '0;
      else        q_q <= (clr_i ? '0 : q_q) | set_i;
   end

   assign q_o = q_q;
endmodule

// File: rtl/wake_status_reg.sv
module wake_status_reg
   import wake_pkg::*;
#(
   parameter int unsigned     IDX_W       = 8,
   parameter logic [IDX_W-1:0] REG_INDEX  = IDX_W'(8'hB2),
   parameter int unsigned     SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              vbat_rst_n,
   input  logic              ser1_ring_n,
   input  logic              ser2_ring_n,
   input  logic              kbd_clk,
   input  logic              mouse_clk,
   input  logic              ir_rx2,
   input  logic              alarm_lvl,
   input  logic              grp_int1,
   input  logic              grp_int2,
   input  logic              cfg_strobe,
   input  logic              cfg_write,
   input  logic [IDX_W-1:0]  cfg_index,
   output logic [STAT_W-1:0] cfg_rdata,
   output logic              wake_req
);
   if (IDX_W < 1) begin : g_bad_idx
      $error("wake_status_reg: IDX_W must be at least 1");
   end

   logic [NUM_PINS-1:0] pin_raw, pin_sync, pin_fall;
   logic [STAT_W-1:0]   set_vec, sticky_q, live_vec, status;
   logic                rd_any, rd_hit;

   assign pin_raw = {ir_rx2, mouse_clk, kbd_clk, ser2_ring_n, ser1_ring_n};

   wake_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (vbat_rst_n),
      .d_i   (pin_raw),
      .q_o   (pin_sync)
   );

   wake_fall_det #(.WIDTH(NUM_PINS)) u_fall (
      .clk    (clk),
      .rst_n  (vbat_rst_n),
      .lvl_i  (pin_sync),
      .fall_o (pin_fall)
   );

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_map
      localparam int unsigned POS = pin_pos(g);
      assign set_vec[POS] = pin_fall[g];
   end
   assign set_vec[BIT_ALARM] = alarm_lvl;
   assign set_vec[BIT_GI1]   = 1'b0;
   assign set_vec[BIT_GI2]   = 1'b0;

   assign rd_any = cfg_strobe & ~cfg_write;
   assign rd_hit = rd_any & (cfg_index == REG_INDEX);

   wake_sticky_bank #(.WIDTH(STAT_W)) u_sticky (
      .clk   (clk),
      .rst_n (vbat_rst_n),
      .set_i (set_vec),
      .clr_i (rd_hit),
      .q_o   (sticky_q)
   );

   always_comb begin
      live_vec          = '0;
      live_vec[BIT_GI1] = grp_int1;
      live_vec[BIT_GI2] = grp_int2;
   end

   assign status   = (sticky_q & ~LIVE_MASK) | live_vec;
   assign wake_req = |status;

   always_ff @(posedge clk or negedge vbat_rst_n) begin
      if (!vbat_rst_n)  cfg_rdata <= '0;
      else if (rd_any)  cfg_rdata <= rd_hit ? status : '0;
   end
endmodule

// File: rtl/wake_status_chk.sv
module wake_status_chk #(
   parameter int unsigned      IDX_W     = 8,
   parameter logic [IDX_W-1:0] REG_INDEX = IDX_W'(8'hB2)
) (
   input logic             clk,
   input logic             vbat_rst_n,
   input logic             cfg_strobe,
   input logic             cfg_write,
   input logic [IDX_W-1:0] cfg_index,
   input logic [7:0]       cfg_rdata,
   input logic             alarm_lvl,
   input logic             grp_int1,
   input logic             grp_int2,
   input logic             wake_req,
   input logic             alarm_sticky
);
   // R1
   reset_clean_chk: assert property (@(posedge clk) disable iff (!vbat_rst_n)
      $rose(vbat_rst_n) |-> (cfg_rdata == 8'h00) && !alarm_sticky);

   // R2
   other_index_zero_chk: assert property (@(posedge clk) disable iff (!vbat_rst_n)
      (cfg_strobe && !cfg_write && cfg_index != REG_INDEX) |=> (cfg_rdata == 8'h00));

   // R5
   alarm_sets_chk: assert property (@(posedge clk) disable iff (!vbat_rst_n)
      alarm_lvl |=> alarm_sticky);

   // R7
   live_bits_chk: assert property (@(posedge clk) disable iff (!vbat_rst_n)
      (cfg_strobe && !cfg_write && cfg_index == REG_INDEX)
      |=> (cfg_rdata[5:4] == $past({grp_int2, grp_int1})));

   // R6
   read_clears_alarm_chk: assert property (@(posedge clk) disable iff (!vbat_rst_n)
      (cfg_strobe && !cfg_write && cfg_index == REG_INDEX && !alarm_lvl) |=> !alarm_sticky);

   // R9
   wake_live_chk: assert property (@(posedge clk) disable iff (!vbat_rst_n)
      (grp_int1 || grp_int2 || alarm_sticky) |-> wake_req);

   // R10
   write_ignored_chk: assert property (@(posedge clk) disable iff (!vbat_rst_n)
      (cfg_strobe && cfg_write) |=> $stable(cfg_rdata));
endmodule

bind wake_status_reg wake_status_chk #(.IDX_W(IDX_W), .REG_INDEX(REG_INDEX)) u_chk (
   .clk          (clk),
   .vbat_rst_n   (vbat_rst_n),
   .cfg_strobe   (cfg_strobe),
   .cfg_write    (cfg_write),
   .cfg_index    (cfg_index),
   .cfg_rdata    (cfg_rdata),
   .alarm_lvl    (alarm_lvl),
   .grp_int1     (grp_int1),
   .grp_int2     (grp_int2),
   .wake_req     (wake_req),
   .alarm_sticky (sticky_q[7])
);

// File: tb/test_wake_status_reg.sv
`timescale 1ns/1ps
module test_wake_status_reg;
   localparam logic [7:0] IDX = 8'hB2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] pins = 5'h1F;
   logic       alarm = 1'b0;
   logic [1:0] gi = 2'b00;
   logic       stb = 1'b0, wr = 1'b0;
   logic [7:0] idx = 8'h00;
   logic [7:0] rdata;
   logic       wake;

   int errs = 0, checks = 0;
   logic [4:0] ph1 = 5'h1F, ph2 = 5'h1F, ph3 = 5'h1F;
   logic [7:0] m_sticky = 8'h00, m_rdata = 8'h00;

   always #2.5 clk = ~clk;

   wake_status_reg i_wake_status_reg (
      .clk(clk), .vbat_rst_n(rst_n),
      .ser1_ring_n(pins[0]), .ser2_ring_n(pins[1]), .kbd_clk(pins[2]),
      .mouse_clk(pins[3]), .ir_rx2(pins[4]),
      .alarm_lvl(alarm), .grp_int1(gi[0]), .grp_int2(gi[1]),
      .cfg_strobe(stb), .cfg_write(wr), .cfg_index(idx),
      .cfg_rdata(rdata), .wake_req(wake)
   );

   function automatic logic [7:0] pin_bit(input int i);
      return (i == 4) ? 8'h40 : (8'h01 << i);
   endfunction

   function automatic logic [7:0] m_status();
      return (m_sticky & 8'hCF) | {2'b00, gi, 4'b0000};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock cycle with the inputs already driven; ends at the next falling edge
   task automatic step(input string tag);
      logic [7:0] setv, stat;
      logic       hit;
      setv = 8'h00;
      for (int i = 0; i < 5; i++) if (ph3[i] && !ph2[i]) setv |= pin_bit(i);
      if (alarm) setv[7] = 1'b1;
      stat = m_status();
      hit = stb && !wr && (idx == IDX);
      @(posedge clk);
      if (stb && !wr) m_rdata = hit ? stat : 8'h00;
      m_sticky = (hit ? 8'h00 : m_sticky) | setv;
      ph3 = ph2; ph2 = ph1; ph1 = pins;
      #1;
      chk(rdata === m_rdata, tag, rdata, m_rdata);
      chk(wake === (|m_status()), "R9", {7'd0, wake}, {7'd0, |m_status()});
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      stb = 0; wr = 0;
      for (int i = 0; i < n; i++) step("R6");
   endtask

   task automatic rd(input string tag, input logic [7:0] exp);
      stb = 1; wr = 0; idx = IDX;
      step(tag);
      chk(rdata === exp, tag, rdata, exp);
      stb = 0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      #(100000 * 5);
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] held;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1 under reset
      chk(rdata === 8'h00 && wake === 1'b0, "R1", rdata, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      idle(2);
      rd("R1", 8'h00);

      // R3 each pin on its own bit, R6 cleared by the read, R4 rising edge sets nothing
      for (int p = 0; p < 5; p++) begin
         pins[p] = 1'b0;
         idle(6);
         rd("R3", pin_bit(p));
         rd("R6", 8'h00);
         pins[p] = 1'b1;
         idle(5);
         rd("R4", 8'h00);
      end

      // R5 alarm, R8 alarm held across a read
      alarm = 1; step("R5"); alarm = 0;
      rd("R5", 8'h80);
      rd("R6", 8'h00);
      alarm = 1; step("R5");
      rd("R8", 8'h80);
      alarm = 0;
      rd("R8", 8'h80);
      rd("R6", 8'h00);

      // R7 live group interrupt bits
      gi = 2'b01; rd("R7", 8'h10);
      chk(wake === 1'b1, "R9", {7'd0, wake}, 8'h01);
      gi = 2'b11; rd("R7", 8'h30);
      gi = 2'b10; rd("R7", 8'h20);
      gi = 2'b00; rd("R7", 8'h00);
      chk(wake === 1'b0, "R9", {7'd0, wake}, 8'h00);

      // R10 write strobe leaves status and read data alone
      pins[2] = 0; idle(4); pins[2] = 1;
      held = rdata;
      stb = 1; wr = 1; idx = IDX; step("R10");
      chk(rdata === held, "R10", rdata, held);
      chk(wake === 1'b1, "R10", {7'd0, wake}, 8'h01);
      idle(3);
      // R2 other index returns zero and keeps the bit
      stb = 1; wr = 0; idx = 8'hB3; step("R2"); stb = 0;
      chk(rdata === 8'h00, "R2", rdata, 8'h00);
      rd("R2", 8'h04);

      // R8 pin edge meeting a read at the same edge
      pins[1] = 0; step("R8");
      step("R8");
      rd("R8", 8'h00);
      rd("R8", 8'h02);
      pins[1] = 1; idle(4);
      rd("R6", 8'h00);

      // random phase
      for (int c = 0; c < 4000; c++) begin
         for (int i = 0; i < 5; i++) if ($urandom_range(0, 7) == 0) pins[i] = ~pins[i];
         alarm = ($urandom_range(0, 31) == 0);
         gi    = ($urandom_range(0, 7) == 0) ? 2'($urandom) : gi;
         stb   = ($urandom_range(0, 3) == 0);
         wr    = ($urandom_range(0, 3) == 0);
         idx   = ($urandom_range(0, 4) == 0) ? 8'($urandom) : IDX;
         step("R3");
      end
      stb = 0; wr = 0;
      summary();
      $finish;
   end
endmodule